// File: doc/BRIEF.md
# System Control Port Register

This block is a one-byte control register on a simple I/O bus. The bus gives it an address, write data, read data, a read strobe and a write strobe. The register answers at a single port address and stores every bit that is written to it. A read at that address returns the whole stored byte.

Two of the stored bits control outside logic:

- **Bit 1** drives the address-line-20 gate enable output.
- **Bit 0** is a fast reset request. When a write moves this bit from 0 to 1, the block sends a single-cycle pulse to the system reset logic.

The block has two kinds of reset:

- **Power-on reset** clears the whole byte.
- **Device reset** (`soft_rst`) clears only bit 0. The gate setting survives it.

The pulse comes from a two-state machine:

- **`PLS_IDLE`**: no request is pending. It moves to `PLS_FIRE` on a qualifying rising write. Otherwise it stays in `PLS_IDLE`.
- **`PLS_FIRE`**: the request output is high for this cycle. It returns to `PLS_IDLE`, or stays in `PLS_FIRE` if another qualifying write arrives in the same cycle.

Top module: `sysctl_port`

## Requirements
- R1: The register responds only when the full `ADDR_W`-bit address equals `PORT_ADDR` (default 0x0092). A read or write at any other address has no effect on the register.
- R2: A write at the port address stores all 8 data bits. A read at the port address returns the stored byte on `bus_rdata` in the same cycle, with no extra latency.
- R3: `gate_a20` equals bit 1 of the stored byte. It changes in the cycle after every write to the port.
- R4: `rst_req` is high for exactly one clock cycle, starting in the cycle after a write that sets bit 0 while the stored bit 0 was 0.
- R5: A write with bit 0 = 1 over a stored bit 0 of 1 gives no pulse. A write with bit 0 = 0 never gives a pulse.
- R6: While `rst_n` is low, and after it is released, the stored byte is 0x00, `gate_a20` is 0 and `rst_req` is 0.
- R7: A device reset (`soft_rst` high for a cycle, with no write to the port) clears bit 0 and keeps bits 7..1. `gate_a20` is therefore unchanged.
- R8: `bus_rdata` is 0x00 unless a read strobe is active at the port address.
- R9: When a port write and `soft_rst` happen in the same cycle, the write wins and the full written byte is stored. The rising-edge test for bit 0 uses the value stored before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst | input | 1 | Device reset, synchronous, active high |
| bus_addr | input | ADDR_W | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data; zero when not selected |
| gate_a20 | output | 1 | Address-line-20 gate enable (stored bit 1) |
| rst_req | output | 1 | One-cycle system reset request pulse |

## Verification
The bench targets these corner cases:

- **Writing 1 over a stored 1.** A design that triggers on level rather than edge would fire a second pulse here.
- **Device reset followed by a write of 1.** This must fire again. A design that forgets the cleared bit would stay silent.
- **Device reset alone.** A design that clears the whole byte would lose the gate setting.
- **Write and device reset in the same cycle.** A design that gives reset priority would drop the stored byte or the pulse.
- **Neighbouring addresses.** A design with partial address decode would respond to them.
- **Reads while not selected.** A design that does not gate its read data would leak the stored byte.

Random traffic mixes all of these with a fixed seed.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [0:0] {
        PLS_IDLE = 1'b0,
        PLS_FIRE = 1'b1
    } pulse_state_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
    parameter int unsigned        ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  PORT_ADDR = 16'h0092
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic sel;

    always_comb begin
        sel    = (bus_addr == PORT_ADDR);
        wr_hit = sel && bus_wr;
        rd_hit = sel && bus_rd;
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
    parameter int unsigned DATA_W  = sysctl_pkg::BYTE_W,
    parameter int unsigned RST_BIT = 0,
    parameter int unsigned GATE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q,
    output logic              rise
);
    localparam logic [DATA_W-1:0] SOFT_MASK = ~(DATA_W'(1) << RST_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_hit) begin
            q <= wdata;
        end else if (soft_rst) begin
            q <= q & SOFT_MASK;
        end
    end

    always_comb begin
        rise = wr_hit && wdata[RST_BIT] && !q[RST_BIT];
    end

    // R2 and R3: a write lands whole, including the gate bit
    p_write_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (q == $past(wdata)) && (q[GATE_BIT] == $past(wdata[GATE_BIT])));

    // R7: device reset alone keeps the upper bits and clears bit 0
    p_soft_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !wr_hit) |=> ((q & SOFT_MASK) == ($past(q) & SOFT_MASK)) && !q[RST_BIT]);

    // R1: without a write or reset the byte holds
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !soft_rst) |=> $stable(q));
endmodule

// File: rtl/sysctl_pulse.sv
module sysctl_pulse
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    output logic req
);
    pulse_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PLS_IDLE: state_nx = rise ? PLS_FIRE : PLS_IDLE;
            PLS_FIRE: state_nx = rise ? PLS_FIRE : PLS_IDLE;
            default:  state_nx = PLS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PLS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            PLS_FIRE: req = 1'b1;
            default:  req = 1'b0;
        endcase
    end

    // R4: every pulse is caused by a rising write one cycle earlier
    p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(rise));

    // R4: a rising write always yields a pulse
    p_pulse_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> req);
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port #(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              gate_a20,
    output logic              rst_req
);
    localparam int unsigned DATA_W   = sysctl_pkg::BYTE_W;
    localparam int unsigned RST_BIT  = 0;
    localparam int unsigned GATE_BIT = 1;

    logic              wr_hit;
    logic              rd_hit;
    logic              rise;
    logic [DATA_W-1:0] stored;

    sysctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) i_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    sysctl_store #(.DATA_W(DATA_W), .RST_BIT(RST_BIT), .GATE_BIT(GATE_BIT)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_hit   (wr_hit),
        .wdata    (bus_wdata),
        .q        (stored),
        .rise     (rise)
    );

    sysctl_pulse i_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise),
        .req   (rst_req)
    );

    always_comb begin
        bus_rdata = rd_hit ? stored : '0;
        gate_a20  = stored[GATE_BIT];
    end

    // R8: other addresses never see read data
    p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != PORT_ADDR || !bus_rd) |-> (bus_rdata == 8'h00));

    // R4: pulse lasts one cycle
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R5: rewriting a set bit 0 gives no pulse
    p_no_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PORT_ADDR && stored[RST_BIT]) |=> !rst_req);

    // R9: write beats device reset in the same cycle
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PORT_ADDR && soft_rst) |=> (gate_a20 == $past(bus_wdata[GATE_BIT])));
endmodule

// File: tb/test_sysctl_port.sv
module test_sysctl_port;
    localparam logic [15:0] PADDR = 16'h0092;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        gate_a20;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q = 8'h00;
    logic       exp_req = 1'b0;

    always #4 clk = ~clk;

    sysctl_port i_sysctl_port (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .gate_a20(gate_a20), .rst_req(rst_req)
    );

    function automatic logic [7:0] f_rdata(input logic [15:0] a, input logic rd, input logic [7:0] q);
        return (rd && a == PADDR) ? q : 8'h00;
    endfunction

    function automatic logic f_rise(input logic [15:0] a, input logic wr, input logic [7:0] d, input logic [7:0] q);
        return wr && (a == PADDR) && d[0] && !q[0];
    endfunction

    function automatic logic [7:0] f_next(input logic [15:0] a, input logic wr, input logic [7:0] d,
                                         input logic sr, input logic [7:0] q);
        if (wr && a == PADDR) return d;
        if (sr) return {q[7:1], 1'b0};
        return q;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called just after a negedge: drive, check read data, step, check outputs
    task automatic cyc(input string tag, input logic [15:0] a, input logic [7:0] d,
                       input logic wr, input logic rd, input logic sr);
        logic r;
        bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = rd; soft_rst = sr;
        #1;
        check({tag, " rdata"}, bus_rdata, f_rdata(a, rd, exp_q));
        r = f_rise(a, wr, d, exp_q);
        exp_q = f_next(a, wr, d, sr, exp_q);
        exp_req = r;
        @(negedge clk);
        check({tag, " a20"}, {7'b0, gate_a20}, {7'b0, exp_q[1]});
        check({tag, " req"}, {7'b0, rst_req}, {7'b0, exp_req});
    endtask

    task automatic rd_port(input string tag);
        cyc(tag, PADDR, 8'h00, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0092));
        @(negedge clk);
        @(negedge clk);
        // R6: state while power-on reset is held
        check("R6 a20 in reset", {7'b0, gate_a20}, 8'h00);
        check("R6 req in reset", {7'b0, rst_req}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd_port("R6 read after power-on");

        // R2 R3: full byte stored, gate follows bit 1
        cyc("R2 write A6", PADDR, 8'hA6, 1'b1, 1'b0, 1'b0);
        rd_port("R2 readback");
        cyc("R3 clear gate", PADDR, 8'hA4, 1'b1, 1'b1, 1'b0);
        // R4: rising bit 0 gives pulse, then quiet
        cyc("R4 rise", PADDR, 8'h03, 1'b1, 1'b0, 1'b0);
        rd_port("R4 pulse ends");
        // R5: 1 over 1, and 0 writes, no pulse
        cyc("R5 rewrite one", PADDR, 8'h07, 1'b1, 1'b0, 1'b0);
        cyc("R5 write zero", PADDR, 8'h06, 1'b1, 1'b0, 1'b0);
        cyc("R5 rise again", PADDR, 8'h07, 1'b1, 1'b0, 1'b0);
        // R7: device reset keeps upper bits
        cyc("R7 soft", 16'h0000, 8'h00, 1'b0, 1'b0, 1'b1);
        rd_port("R7 readback");
        cyc("R7 refire", PADDR, 8'h07, 1'b1, 1'b0, 1'b0);
        // R1 R8: neighbours ignored and read quiet
        cyc("R1 addr 93", 16'h0093, 8'h00, 1'b1, 1'b1, 1'b0);
        cyc("R1 addr 192", 16'h0192, 8'hFE, 1'b1, 1'b1, 1'b0);
        cyc("R8 no strobe", PADDR, 8'h00, 1'b0, 1'b0, 1'b0);
        rd_port("R1 unchanged");
        // R9: write and soft reset together
        cyc("R7 clear b0", 16'h0000, 8'h00, 1'b0, 1'b0, 1'b1);
        cyc("R9 write wins", PADDR, 8'h5B, 1'b1, 1'b0, 1'b1);
        rd_port("R9 readback");
        // R6: power-on reset mid-run clears all
        rst_n = 1'b0;
        exp_q = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        rd_port("R6 second power-on");

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            a = ($urandom % 3 != 0) ? PADDR : 16'($urandom);
            cyc("R2 R3 R4 R5 R7 R9 random", a, 8'($urandom),
                1'($urandom % 3 == 0), 1'($urandom), 1'($urandom % 4 == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule